// File: doc/BRIEF.md
# SDRAM Power-Up Init Sequencer

This block walks a DDR SDRAM from the clock-enabled state to normal operation. After a single-cycle `start_i` pulse it issues seven commands in a fixed order: precharge-all, extended mode set, mode set with the device DLL reset, a second precharge-all, two auto-refreshes, and a closing mode set without DLL reset. Each command is presented for one cycle on `cmd_o` with `cmd_valid_o`. The value to drive onto the address pins is placed on `mode_val_o` at the same time.

After each command the sequencer waits at least a minimum number of cycles, taken from a timing field that matches the command type. It then also waits until the physical command path drops `phy_busy_i`. If the path stays busy for too long, the sequence stops and reports an error. The clock frequency in MHz selects one of three timing tiers, published on `tcfg_o` for the rest of the controller. The same frequency sets the periodic refresh divisor. Periodic refresh is enabled only once the whole sequence has finished. The fast/slow select changes the mode words, and in slow operation it leaves the device DLL disabled.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and after it is released, `cmd_valid_o`, `busy_o`, `done_o`, `error_o` and `refresh_en_o` are 0 and `cmd_o` is NOP (0).
- R2: A start pulse accepted while idle, done or in error issues exactly seven commands in this order: precharge, extended mode, mode, precharge, refresh, refresh, mode.
- R3: `cmd_valid_o` is high for exactly one cycle per command. Command codes are NOP=0, PRECHARGE=1, EXT_MODE=2, MODE=3, REFRESH=4, and `cmd_o` reads NOP whenever `cmd_valid_o` is low.
- R4: With `fast_i`=1, the extended mode value is 0x000, the first mode value is 0x161 and the final mode value is 0x061. Every precharge carries 0x400 (the all-banks bit, address bit 10), and every refresh carries 0x000.
- R5: With `fast_i`=0, the extended mode value is 0x001 (device DLL off) and both mode values are 0x021.
- R6: `tcfg_o` packs {write recovery[13:12], active-to-precharge[11:9], precharge[8:7], refresh cycle[6:4], bank cycle[3:0]}. The packed values are 2,5,2,4,7 for a clock at or below 100 MHz; 2,6,3,5,9 at or below 133 MHz; and 3,7,3,6,10 above that. The frequency is captured at start.
- R7: With `phy_busy_i` low, each command follows the previous one by N+1 cycles, and `done_o` rises N+1 cycles after the last command. N is the precharge field after a precharge, the write-recovery field after either mode set, and the bank-cycle field after a refresh.
- R8: While `phy_busy_i` is high, the sequencer holds the current step; the next command is issued in the cycle after `phy_busy_i` falls, once the minimum wait has passed.
- R9: If a step is still not complete after TOUT_CYC (default 64) cycles of waiting, `error_o` rises in the next cycle. No further command is issued, `busy_o` and `refresh_en_o` are 0, and `error_o` holds until the next start.
- R10: `refresh_en_o` is 0 from start until the sequence completes and rises together with `done_o`. `refresh_div_o` equals floor(MHz × 125 / 16), which is MHz × 7.8125 truncated.
- R11: `done_o` holds until the next start pulse, which clears `done_o` and `refresh_en_o` and begins a new sequence.
- R12: A start pulse while `busy_o` is high has no effect on the command stream in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the init sequence (pulse) |
| fast_i | input | 1 | 1 = fast operation with device DLL on, 0 = slow |
| clk_mhz_i | input | MHZ_W (9) | Memory clock frequency in MHz |
| phy_busy_i | input | 1 | Command path still executing the last command |
| cmd_o | output | 3 | Command code |
| cmd_valid_o | output | 1 | Command strobe, one cycle |
| mode_val_o | output | MODE_W (14) | Address / mode value for the command |
| tcfg_o | output | 14 | Selected timing fields |
| refresh_en_o | output | 1 | Periodic refresh enable |
| refresh_div_o | output | DIV_W (12) | Periodic refresh divisor |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |
| error_o | output | 1 | A step timed out |

## Verification
The assertions assume that `start_i` is a clean pulse sampled on the clock. They also assume that `phy_busy_i` changes only between edges and reflects the command just issued, so a falling edge of `phy_busy_i` can be taken as step completion. The bench drives every input at the falling edge. It holds `clk_mhz_i` and `fast_i` steady from start to the end of a sequence. It raises `phy_busy_i` only across a single step, either for a bounded stretch or until the timeout is reached, so the minimum-wait and hold-off windows can be checked cycle-exactly.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PRE  = 3'd1,
    CMD_EMRS = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_REF  = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE,
    ST_ERR
  } state_e;

  // field order sets tcfg bit layout, MSB first
  typedef struct packed {
    logic [1:0] wr;
    logic [2:0] act;
    logic [1:0] pre;
    logic [2:0] rfc;
    logic [3:0] bank;
  } timing_t;

  localparam int unsigned NUM_STEPS = 7;
endpackage

// File: rtl/sdram_timing_sel.sv
module sdram_timing_sel
  import sdram_init_pkg::*;
#(
  parameter int unsigned MHZ_W   = 9,
  parameter int unsigned DIV_W   = 12,
  parameter int unsigned LO_MHZ  = 100,
  parameter int unsigned MID_MHZ = 133
) (
  input  logic [MHZ_W-1:0] mhz_i,
  output timing_t          timing_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int unsigned PROD_W = MHZ_W + 7;

  logic [PROD_W-1:0] prod;

  // 7.8125 us interval = mhz * 125 / 16
  assign prod  = PROD_W'(mhz_i) * PROD_W'(125);
  assign div_o = DIV_W'(prod >> 4);

  always_comb begin
    if (mhz_i <= MHZ_W'(LO_MHZ)) begin
      timing_o = '{wr: 2'd2, act: 3'd5, pre: 2'd2, rfc: 3'd4, bank: 4'd7};
    end else if (mhz_i <= MHZ_W'(MID_MHZ)) begin
      timing_o = '{wr: 2'd2, act: 3'd6, pre: 2'd3, rfc: 3'd5, bank: 4'd9};
    end else begin
      timing_o = '{wr: 2'd3, act: 3'd7, pre: 2'd3, rfc: 3'd6, bank: 4'd10};
    end
  end
endmodule

// File: rtl/sdram_step_decode.sv
module sdram_step_decode
  import sdram_init_pkg::*;
#(
  parameter int unsigned MODE_W = 14,
  parameter int unsigned STEP_W = 3
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic              fast_i,
  input  logic [1:0]        pre_i,
  input  logic [1:0]        wr_i,
  input  logic [3:0]        bank_i,
  output cmd_e              cmd_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [3:0]        wait_o
);
  localparam logic [MODE_W-1:0] ALL_BANKS = MODE_W'(14'h400);
  localparam logic [MODE_W-1:0] MRS_DLLR  = MODE_W'(14'h161);
  localparam logic [MODE_W-1:0] MRS_FAST  = MODE_W'(14'h061);
  localparam logic [MODE_W-1:0] MRS_SLOW  = MODE_W'(14'h021);

  always_comb begin
    cmd_o  = CMD_NOP;
    mode_o = '0;
    wait_o = 4'd1;
    case (step_i)
      STEP_W'(0), STEP_W'(3): begin
        cmd_o  = CMD_PRE;
        mode_o = ALL_BANKS;
        wait_o = {2'b00, pre_i};
      end
      STEP_W'(1): begin
        cmd_o  = CMD_EMRS;
        mode_o = fast_i ? '0 : MODE_W'(1);
        wait_o = {2'b00, wr_i};
      end
      STEP_W'(2): begin
        cmd_o  = CMD_MRS;
        mode_o = fast_i ? MRS_DLLR : MRS_SLOW;
        wait_o = {2'b00, wr_i};
      end
      STEP_W'(4), STEP_W'(5): begin
        cmd_o  = CMD_REF;
        mode_o = '0;
        wait_o = bank_i;
      end
      STEP_W'(6): begin
        cmd_o  = CMD_MRS;
        mode_o = fast_i ? MRS_FAST : MRS_SLOW;
        wait_o = {2'b00, wr_i};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_step_timer.sv
module sdram_step_timer #(
  parameter int unsigned TOUT_CYC = 64,
  parameter int unsigned MIN_W    = 4,
  localparam int unsigned TOUT_W  = (TOUT_CYC > 1) ? $clog2(TOUT_CYC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MIN_W-1:0] min_i,
  input  logic             active_i,
  input  logic             hold_i,
  output logic             ok_o,
  output logic             expire_o
);
  logic [MIN_W-1:0]  min_q;
  logic [TOUT_W-1:0] tout_q;

  assign ok_o     = active_i && (min_q == '0) && !hold_i;
  assign expire_o = active_i && !ok_o && (tout_q == TOUT_W'(TOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q  <= '0;
      tout_q <= '0;
    end else if (load_i) begin
      min_q  <= (min_i == '0) ? '0 : min_i - MIN_W'(1);
      tout_q <= '0;
    end else if (active_i) begin
      if (min_q != '0) min_q <= min_q - MIN_W'(1);
      if (!ok_o && !expire_o) tout_q <= tout_q + TOUT_W'(1);
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned MHZ_W    = 9,
  parameter int unsigned DIV_W    = 12,
  parameter int unsigned MODE_W   = 14,
  parameter int unsigned TOUT_CYC = 64,
  localparam int unsigned STEP_W  = $clog2(NUM_STEPS),
  localparam int unsigned TCFG_W  = $bits(timing_t)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fast_i,
  input  logic [MHZ_W-1:0]  clk_mhz_i,
  input  logic              phy_busy_i,
  output logic [2:0]        cmd_o,
  output logic              cmd_valid_o,
  output logic [MODE_W-1:0] mode_val_o,
  output logic [TCFG_W-1:0] tcfg_o,
  output logic              refresh_en_o,
  output logic [DIV_W-1:0]  refresh_div_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  logic              fast_q;
  logic [MHZ_W-1:0]  mhz_q;
  logic              ren_q;

  timing_t           timing;
  cmd_e              step_cmd;
  logic [MODE_W-1:0] step_mode;
  logic [3:0]        step_wait;
  logic              step_ok;
  logic              step_expire;
  logic              can_start;

  sdram_timing_sel #(
    .MHZ_W (MHZ_W),
    .DIV_W (DIV_W)
  ) u_tsel (
    .mhz_i    (mhz_q),
    .timing_o (timing),
    .div_o    (refresh_div_o)
  );

  sdram_step_decode #(
    .MODE_W (MODE_W),
    .STEP_W (STEP_W)
  ) u_dec (
    .step_i (step_q),
    .fast_i (fast_q),
    .pre_i  (timing.pre),
    .wr_i   (timing.wr),
    .bank_i (timing.bank),
    .cmd_o  (step_cmd),
    .mode_o (step_mode),
    .wait_o (step_wait)
  );

  sdram_step_timer #(
    .TOUT_CYC (TOUT_CYC),
    .MIN_W    (4)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (state_q == ST_ISSUE),
    .min_i    (step_wait),
    .active_i (state_q == ST_WAIT),
    .hold_i   (phy_busy_i),
    .ok_o     (step_ok),
    .expire_o (step_expire)
  );

  assign can_start = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      fast_q  <= 1'b0;
      mhz_q   <= '0;
      ren_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (step_ok) begin
            if (step_q == LAST_STEP) begin
              state_q <= ST_DONE;
              ren_q   <= 1'b1;
            end else begin
              step_q  <= step_q + STEP_W'(1);
              state_q <= ST_ISSUE;
            end
          end else if (step_expire) begin
            state_q <= ST_ERR;
          end
        end
        default: begin
          if (start_i && can_start) begin
            state_q <= ST_ISSUE;
            step_q  <= '0;
            fast_q  <= fast_i;
            mhz_q   <= clk_mhz_i;
            ren_q   <= 1'b0;
          end
        end
      endcase
    end
  end

  assign cmd_valid_o  = (state_q == ST_ISSUE);
  assign cmd_o        = cmd_valid_o ? step_cmd : CMD_NOP;
  assign mode_val_o   = cmd_valid_o ? step_mode : '0;
  assign tcfg_o       = timing;
  assign refresh_en_o = ren_q;
  assign busy_o       = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
  assign done_o       = (state_q == ST_DONE);
  assign error_o      = (state_q == ST_ERR);
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       phy_busy_i,
  input logic [2:0] cmd_o,
  input logic       cmd_valid_o,
  input logic       refresh_en_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       error_o
);
  assert_cmd_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_cmd_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_o != 3'd0 && cmd_o <= 3'd4));

  assert_nop_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> (cmd_o == 3'd0));

  assert_done_refresh_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (refresh_en_o && !busy_o));

  assert_refresh_off_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !refresh_en_o);

  assert_err_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!busy_o && !refresh_en_o && !cmd_valid_o && !done_o));

  assert_err_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> error_o);

  assert_done_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_phy_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !$past(phy_busy_i));
endmodule

bind sdram_init_seq sdram_init_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .phy_busy_i   (phy_busy_i),
  .cmd_o        (cmd_o),
  .cmd_valid_o  (cmd_valid_o),
  .refresh_en_o (refresh_en_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .error_o      (error_o)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        fast_i = 1'b1;
  logic [8:0]  clk_mhz_i = 9'd125;
  logic        phy_busy_i = 1'b0;
  logic [2:0]  cmd_o;
  logic        cmd_valid_o;
  logic [13:0] mode_val_o;
  logic [13:0] tcfg_o;
  logic        refresh_en_o;
  logic [11:0] refresh_div_o;
  logic        busy_o, done_o, error_o;

  int n_chk = 0, n_fail = 0, cyc = 0, ncmd = 0;
  int mcmd[16], mval[16], mcyc[16], mren[16];
  int end_cyc;

  sdram_init_seq u_dut (.*);

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (cmd_valid_o && ncmd < 16) begin
      mcmd[ncmd] = int'(cmd_o);
      mval[ncmd] = int'(mode_val_o);
      mcyc[ncmd] = cyc;
      mren[ncmd] = int'(refresh_en_o);
      ncmd = ncmd + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // tier fields {wr, act, pre, rfc, bank}
  function automatic int fld(input int mhz, input int sel);
    int t[5];
    if (mhz <= 100) t = '{2, 5, 2, 4, 7};
    else if (mhz <= 133) t = '{2, 6, 3, 5, 9};
    else t = '{3, 7, 3, 6, 10};
    return t[sel];
  endfunction

  function automatic int exp_wait(input int cmd, input int mhz);
    if (cmd == 1) return fld(mhz, 2);
    if (cmd == 4) return fld(mhz, 4);
    return fld(mhz, 0);
  endfunction

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 600; i++) begin
      if (done_o || error_o) break;
      @(negedge clk_i);
    end
    end_cyc = cyc;
  endtask

  task automatic check_run(input bit fast, input int mhz, input bool_spacing);
    int order[7] = '{1, 2, 3, 1, 4, 4, 3};
    int vals[7];
    int tc;
    if (fast) vals = '{'h400, 'h000, 'h161, 'h400, 0, 0, 'h061};
    else vals = '{'h400, 'h001, 'h021, 'h400, 0, 0, 'h021};
    check(ncmd == 7, "R2 count", ncmd, 7);
    for (int i = 0; i < 7; i++) begin
      check(mcmd[i] == order[i], "R2/R3 order", mcmd[i], order[i]);
      check(mval[i] == vals[i], fast ? "R4 fast value" : "R5 slow value", mval[i], vals[i]);
      check(mren[i] == 0, "R10 refresh off", mren[i], 0);
    end
    if (bool_spacing) begin
      for (int i = 0; i < 6; i++)
        check(mcyc[i+1] - mcyc[i] == exp_wait(order[i], mhz) + 1, "R7 spacing",
              mcyc[i+1] - mcyc[i], exp_wait(order[i], mhz) + 1);
      check(end_cyc - mcyc[6] == fld(mhz, 0) + 1, "R7 done delay",
            end_cyc - mcyc[6], fld(mhz, 0) + 1);
    end
    check(done_o && !error_o && !busy_o, "R11 done", {done_o, error_o, busy_o}, 3'b100);
    check(refresh_en_o == 1'b1, "R10 refresh on", refresh_en_o, 1);
    check(refresh_div_o == 12'((mhz * 125) / 16), "R10 divisor", refresh_div_o, (mhz * 125) / 16);
    tc = (fld(mhz, 0) << 12) | (fld(mhz, 1) << 9) | (fld(mhz, 2) << 7) | (fld(mhz, 3) << 4) | fld(mhz, 4);
    check(tcfg_o == 14'(tc), "R6 tcfg", tcfg_o, tc);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check({cmd_valid_o, busy_o, done_o, error_o, refresh_en_o} == 0, "R1 in reset",
          {cmd_valid_o, busy_o, done_o, error_o, refresh_en_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check({cmd_valid_o, busy_o, done_o, error_o, refresh_en_o} == 0 && cmd_o == 0, "R1 after reset",
          {cmd_o, cmd_valid_o, busy_o, done_o, error_o, refresh_en_o}, 0);
  endtask

  task automatic t_run(input bit fast, input int mhz);
    fast_i = fast; clk_mhz_i = 9'(mhz); ncmd = 0;
    pulse_start();
    check(busy_o == 1'b1, "R11 busy after start", busy_o, 1);
    wait_end();
    check_run(fast, mhz, 1'b1);
  endtask

  task automatic t_done_hold();
    int n0 = ncmd;
    repeat (20) @(negedge clk_i);
    check(done_o && refresh_en_o, "R11 done held", {done_o, refresh_en_o}, 3);
    check(ncmd == n0, "R11 no extra cmd", ncmd, n0);
  endtask

  task automatic t_start_ignored();
    fast_i = 1'b1; clk_mhz_i = 9'd125; ncmd = 0;
    pulse_start();
    while (ncmd < 3) @(negedge clk_i);
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    wait_end();
    check_run(1'b1, 125, 1'b1);  // R12 stream unchanged
  endtask

  task automatic t_phy_hold();
    fast_i = 1'b1; clk_mhz_i = 9'd125; ncmd = 0;
    phy_busy_i = 1'b1;
    pulse_start();
    repeat (20) @(negedge clk_i);
    check(ncmd == 1 && busy_o, "R8 held", ncmd, 1);
    phy_busy_i = 1'b0;
    wait_end();
    check(mcyc[1] - mcyc[0] == 21, "R8 release gap", mcyc[1] - mcyc[0], 21);
    check_run(1'b1, 125, 1'b0);
  endtask

  task automatic t_timeout();
    int err_cyc = 0;
    fast_i = 1'b0; clk_mhz_i = 9'd100; ncmd = 0;
    phy_busy_i = 1'b1;
    pulse_start();
    wait_end();
    err_cyc = end_cyc;
    check(error_o && !done_o, "R9 error", {error_o, done_o}, 2);
    check(err_cyc - mcyc[0] == 65, "R9 timeout cycles", err_cyc - mcyc[0], 65);
    repeat (10) @(negedge clk_i);
    check(ncmd == 1, "R9 no further cmd", ncmd, 1);
    check(error_o && !busy_o && !refresh_en_o, "R9 held quiet",
          {error_o, busy_o, refresh_en_o}, 4);
    phy_busy_i = 1'b0;
    t_run(1'b0, 100);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_run(1'b1, 125);
        t_done_hold();
        t_run(1'b0, 100);
        t_run(1'b1, 133);
        t_run(1'b1, 200);
        t_start_ignored();
        t_phy_hold();
        t_timeout();
      end
      begin
        repeat (20000) @(posedge clk_i);
        check(1'b0, "watchdog", cyc, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule